// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software reach the registers of an external PHY over the two-wire management bus. Software sees three 32-bit registers on a simple write-strobe bus with combinational readback. To write a PHY register it loads the 16-bit value into the data register and then issues a write command. To read one it issues a read command. In both cases it then polls the busy flag in the command register until that flag drops.

The engine serializes a complete clause-22 frame on the MDIO line, clocked by an MDC that is a divided copy of the system clock. On a read it releases the line from the turnaround onward and shifts the PHY's reply into the upper half of the data register. If the PHY leaves the line high in the second turnaround bit, the engine raises an invalid-read flag.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command, data and status registers read 0, MDC is low, the MDIO output enable is low and the MDIO output is 1.
- R2: A bus write to offset 0x3C0 starts a transaction when bit 20 (busy) is 1 and exactly one of bit 17 (read) and bit 16 (write) is 1. The PHY address is taken from bits 12:8 and the register number from bits 4:0. Reading 0x3C0 returns bit 20 as 1 until the frame ends and 0 afterwards, together with the stored opcode and fields at the same bit positions.
- R3: A command written while busy is 1 is ignored: the stored fields and the frame in flight are unchanged, and no second frame follows.
- R4: A command write whose bit 20 is 0, or whose bits 17 and 16 are both 0 or both 1, starts nothing: busy stays 0 and MDC stays low.
- R5: A write sends 64 MSB-first bits, all with the output enable high: 32 ones, 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then bits 15:0 of the data register at offset 0x3C4.
- R6: A read sends 32 ones, 01, opcode 10, the address and the register number with the output enable high. The enable is then low for the remaining 18 bit times, which are the turnaround and the data.
- R7: When a read completes, the 16 bits sampled in the data phase, MSB first, appear in bits 31:16 of offset 0x3C4. Bits 15:0 keep the value last written there.
- R8: Bit 0 of offset 0x3D0 is set when a read completes with the second turnaround bit sampled as 1. It is cleared when a read completes with that bit sampled as 0. Write transactions leave it unchanged.
- R9: MDC has a period of 2*DIV_HALF system clocks while a frame runs and is low otherwise. The MDIO output changes only in the cycle in which MDC falls, and MDIO input is sampled as MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A bench PHY model records every bit that is driven at an MDC rise and answers reads with a chosen turnaround level and data word. The main function is tried with writes and reads whose addresses and data are all zeros, all ones or alternating patterns. This separates a field that has been shifted or swapped from one that is correct. A read with a high turnaround followed by a write shows that the invalid flag is set and then held, and a later good read shows that it clears. Malformed commands, and commands written in the middle of a frame, check that neither starts nor alters a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;   // first turnaround bit time
  localparam int DATA_IDX   = 48;   // first data bit time
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [11:0] OFS_CMD  = 12'h3C0;
  localparam logic [11:0] OFS_DATA = 12'h3C4;
  localparam logic [11:0] OFS_STAT = 12'h3D0;

  localparam int BIT_BUSY = 20;
  localparam int BIT_RD   = 17;
  localparam int BIT_WR   = 16;

  // full serial image of one management frame, MSB sent first
  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic        is_rd,
      input logic [4:0]  phy,
      input logic [4:0]  rg,
      input logic [15:0] wval);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] body;
    op   = is_rd ? 2'b10 : 2'b01;
    ta   = is_rd ? 2'b11 : 2'b10;
    body = is_rd ? 16'hFFFF : wval;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, body};
  endfunction

  function automatic logic cmd_valid(input logic [31:0] w);
    return w[BIT_BUSY] && (w[BIT_RD] ^ w[BIT_WR]);
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run && wrap && !mdc_q;
  assign fall_tick = run && wrap &&  mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  is_rd,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_in,
  output logic                  ser_bit,
  output logic [IDX_W-1:0]      bit_idx,
  output logic [15:0]           rd_word,
  output logic                  ta_bad,
  output logic                  frame_done
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic [15:0]           rd_q;
  logic                  ta_q;
  logic                  last_bit;

  assign last_bit   = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign frame_done = fall_tick && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '1;
      idx_q   <= '0;
      rd_q    <= '0;
      ta_q    <= 1'b0;
    end else if (start) begin
      frame_q <= start_frame;
      idx_q   <= '0;
      ta_q    <= 1'b0;
    end else begin
      if (rise_tick && is_rd) begin
        if (idx_q == IDX_W'(TA_IDX + 1)) ta_q <= mdio_in;
        if (idx_q >= IDX_W'(DATA_IDX))   rd_q <= {rd_q[14:0], mdio_in};
      end
      if (fall_tick && !last_bit) begin
        idx_q   <= idx_q + IDX_W'(1);
        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
      end
    end
  end

  assign ser_bit = frame_q[FRAME_BITS-1];
  assign bit_idx = idx_q;
  assign rd_word = rd_q;
  assign ta_bad  = ta_q;
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             busy_q, op_rd_q, op_wr_q;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      wval_q, rval_q;
  logic             inval_q;

  logic             sel_cmd, sel_data, sel_stat;
  logic             cmd_accept;
  logic             rise_tick, fall_tick, frame_done;
  logic             ser_bit, ta_bad;
  logic [IDX_W-1:0] bit_idx;
  logic [15:0]      rd_word;
  logic [FRAME_BITS-1:0] start_frame;
  logic             in_rx_phase;

  assign sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));

  assign cmd_accept  = bus_wr && sel_cmd && !busy_q && cmd_valid(bus_wdata);
  assign start_frame = build_frame(bus_wdata[BIT_RD], bus_wdata[12:8],
                                   bus_wdata[4:0], wval_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      op_wr_q <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wval_q  <= '0;
      rval_q  <= '0;
      inval_q <= 1'b0;
    end else begin
      if (cmd_accept) begin
        busy_q  <= 1'b1;
        op_rd_q <= bus_wdata[BIT_RD];
        op_wr_q <= bus_wdata[BIT_WR];
        phy_q   <= bus_wdata[12:8];
        reg_q   <= bus_wdata[4:0];
      end else if (frame_done) begin
        busy_q <= 1'b0;
        if (op_rd_q) begin
          rval_q  <= rd_word;
          inval_q <= ta_bad;
        end
      end
      if (bus_wr && sel_data) wval_q <= bus_wdata[15:0];
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shifter ser_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cmd_accept),
    .start_frame (start_frame),
    .is_rd       (op_rd_q),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .mdio_in     (mdio_i),
    .ser_bit     (ser_bit),
    .bit_idx     (bit_idx),
    .rd_word     (rd_word),
    .ta_bad      (ta_bad),
    .frame_done  (frame_done)
  );

  assign in_rx_phase = op_rd_q && (bit_idx >= IDX_W'(TA_IDX));
  assign mdio_o  = busy_q ? ser_bit : 1'b1;
  assign mdio_oe = busy_q && !in_rx_phase;

  always_comb begin
    bus_rdata = '0;
    if (sel_cmd)
      bus_rdata = {11'b0, busy_q, 2'b0, op_rd_q, op_wr_q, 3'b0, phy_q, 3'b0, reg_q};
    else if (sel_data)
      bus_rdata = {rval_q, wval_q};
    else if (sel_stat)
      bus_rdata = {31'b0, inval_q};
  end
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             op_rd,
  input logic             inval,
  input logic             cmd_accept,
  input logic             frame_done,
  input logic [IDX_W-1:0] bit_idx,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  // R9: clock parked low between frames
  a_r9_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R9: output only moves with a falling MDC
  a_r9_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> ($past(mdc) && !mdc));

  // R3: nothing is accepted mid-frame
  a_r3_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_accept);

  // R6: line released for turnaround and data of a read
  a_r6_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_rd && bit_idx >= IDX_W'(TA_IDX)) |-> !mdio_oe);

  // R2: busy only drops at the end of a frame
  a_r2_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_done));

  // R2: every frame begins at bit time zero
  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bit_idx == '0));

  // R8: flag only moves when a read completes
  a_r8_flag_on_read_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inval) |-> $past(frame_done && op_rd));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_q),
  .op_rd      (op_rd_q),
  .inval      (inval_q),
  .cmd_accept (cmd_accept),
  .frame_done (frame_done),
  .bit_idx    (bit_idx),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio_cmd_engine_tb_top.sv
module mdio_cmd_engine_tb_top;
  localparam int DIV = 2;
  localparam logic [11:0] A_CMD  = 12'h3C0;
  localparam logic [11:0] A_DATA = 12'h3C4;
  localparam logic [11:0] A_STAT = 12'h3D0;

  // {rd, ta_high, phy[4:0], reg[4:0], value[15:0]}
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 1'b0, 5'd1,  5'd0,  16'h1234},
    {1'b1, 1'b0, 5'd3,  5'd2,  16'hBEEF},
    {1'b0, 1'b0, 5'd31, 5'd31, 16'hFFFF},
    {1'b1, 1'b1, 5'd0,  5'd1,  16'h0000},
    {1'b0, 1'b0, 5'd10, 5'd21, 16'hA5A5},
    {1'b1, 1'b0, 5'd21, 5'd10, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mdio_cmd_engine #(.DIV_HALF(DIV), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and line monitor
  logic        phy_ta = 1'b0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap = '0, cap_oe = '0, last_cap = '0, last_oe = '0;
  int          nrise = 0;
  int          frame_cnt = 0;
  int          cyc = 0, last_rise = 0;
  logic        mdc_prev = 1'b0;
  bit          period_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!mdc_prev && mdc) begin
      if (nrise > 0 && (cyc - last_rise) != 2*DIV) period_bad = 1;
      last_rise = cyc;
      cap[63-nrise]    = mdio_oe ? mdio_o : 1'b0;
      cap_oe[63-nrise] = mdio_oe;
      nrise = nrise + 1;
      if (nrise == 64) begin
        last_cap  = cap;
        last_oe   = cap_oe;
        frame_cnt = frame_cnt + 1;
        nrise     = 0;
      end
    end else if (mdc_prev && !mdc) begin
      if (nrise == 0 || nrise < 47) mdio_i = 1'b1;
      else if (nrise == 47)         mdio_i = phy_ta;
      else                          mdio_i = phy_val[63-nrise];
    end
    mdc_prev = mdc;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 5000; k++) begin
      bus_read(A_CMD, d);
      if (!d[20]) return;
    end
    chk("R2 busy timeout", 1, 0);
  endtask

  function automatic logic [31:0] mk_cmd(input logic rd, input logic [4:0] p, input logic [4:0] r);
    return 32'h0010_0000 | (rd ? 32'h0002_0000 : 32'h0001_0000)
           | {19'b0, p, 8'b0} | {27'b0, r};
  endfunction

  initial begin
    logic [31:0] d;
    logic        exp_inv;
    logic [15:0] last_w;
    int          fc;
    exp_inv = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    bus_read(A_CMD, d);  chk("R1 cmd reset", d, 0);
    bus_read(A_DATA, d); chk("R1 data reset", d, 0);
    bus_read(A_STAT, d); chk("R1 status reset", d, 0);
    chk("R1 line idle", {mdc, mdio_oe, mdio_o}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 line idle after release", {mdc, mdio_oe, mdio_o}, 3'b001);

    for (int i = 0; i < 6; i++) begin
      logic        rd, tah;
      logic [4:0]  p, r;
      logic [15:0] v;
      {rd, tah, p, r, v} = VEC[i];
      phy_ta = tah; phy_val = v;
      last_w = rd ? ~v : v;
      bus_write(A_DATA, {16'h0, last_w});
      fc = frame_cnt;
      bus_write(A_CMD, mk_cmd(rd, p, r));
      bus_read(A_CMD, d);
      chk("R2 busy and fields after start", d, {11'b0, 1'b1, 2'b0, rd, ~rd, 3'b0, p, 3'b0, r});
      wait_idle();
      bus_read(A_CMD, d);
      chk("R2 busy clears", d[20], 0);
      repeat (4) @(negedge clk);
      chk("R2 one frame", frame_cnt, fc + 1);
      if (!rd) begin
        chk("R5 write frame", last_cap, {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, v});
        chk("R5 enable whole frame", last_oe, {64{1'b1}});
      end else begin
        chk("R6 read header", last_cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, p, r});
        chk("R6 enable released", last_oe, {{46{1'b1}}, 18'b0});
        exp_inv = tah;
        bus_read(A_DATA, d);
        chk("R7 read data high half", d[31:16], v);
      end
      bus_read(A_DATA, d);
      chk("R7 low half kept", d[15:0], last_w);
      bus_read(A_STAT, d);
      chk("R8 invalid flag", d, {31'b0, exp_inv});
    end
    chk("R9 MDC period", period_bad, 0);

    // R3: command during a frame is ignored
    bus_write(A_DATA, 32'h0000_0F0F);
    fc = frame_cnt;
    bus_write(A_CMD, mk_cmd(1'b0, 5'd5, 5'd6));
    repeat (20) @(negedge clk);
    bus_write(A_CMD, mk_cmd(1'b1, 5'd9, 5'd9));
    bus_read(A_CMD, d);
    chk("R3 fields unchanged", d, {11'b0, 1'b1, 2'b0, 2'b01, 3'b0, 5'd5, 3'b0, 5'd6});
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R3 single frame", frame_cnt, fc + 1);
    chk("R3 frame intact", last_cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h0F0F});

    // R4: malformed commands
    fc = frame_cnt;
    bus_write(A_CMD, 32'h0013_0203);
    bus_read(A_CMD, d);  chk("R4 both opcodes", d[20], 0);
    bus_write(A_CMD, 32'h0002_0105);
    bus_read(A_CMD, d);  chk("R4 no busy bit", d[20], 0);
    bus_write(A_CMD, 32'h0010_0101);
    bus_read(A_CMD, d);  chk("R4 no opcode", d[20], 0);
    repeat (50) @(negedge clk);
    chk("R4 no frame", frame_cnt, fc);
    chk("R4 MDC stays low", mdc, 0);
    chk("R9 MDC period after all", period_bad, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule